// File: doc/BRIEF.md
# Multi-lane serial converter deserializer

This block collects the serial results of a bank of simultaneously sampled successive-approximation converters and turns them into one wide parallel word per sample period. A common sample strobe starts each period. Within the period the block opens a read window of one system-clock cycle per result bit, shifts one bit into every lane in each window cycle, and drives a serial clock that tells the converters to present the next bit. With the default settings there are 32 lanes of 18 bits, which gives a 576-bit output word at the strobe rate.

The converters are read while they are already converting the next sample. The bits read in a period therefore belong to the conversion started by the previous strobe. After reset the first period carries no valid result, so its word is not flagged. The start of the window is programmable in system clock cycles from the strobe. This lets the capture be placed clear of the converter's busy interval.

Top module: `adc_lane_deser`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, rd_win_o and sclk_o are 0 and word_o is all zeros. No read window opens until the first strobe_i.
- R2: Counting the cycle after the strobe_i edge as cycle 0, rd_win_o is high exactly in cycles ws to ws+17. ws is win_start_i as sampled on that strobe edge, and must lie in 0..PERIOD_CYC-SAMPLE_W (0..32 by default).
- R3: A change of win_start_i between strobes does not move the window of the period in progress.
- R4: sclk_o is high in exactly the cycles that directly follow a cycle with rd_win_o high.
- R5: All lanes capture in the same window cycles, MSB first. The bit present on sdata_i[n] in the k-th window cycle (k from 0) becomes bit 17-k of lane n's sample.
- R6: Lane n's sample occupies word_o[18n+17:18n].
- R7: valid_o is high for exactly one cycle, the cycle right after the last window cycle, and word_o then carries the completed samples.
- R8: word_o does not change except in a cycle where valid_o is high.
- R9: The window that follows the first strobe after reset produces no valid_o, because there is no earlier conversion.
- R10: If a strobe arrives on the same edge as the last capture, that period's word is still delivered with valid_o, and the new period starts with the newly sampled window start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 40 MHz nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle sample strobe that starts a period |
| win_start_i | input | 6 | Window start in cycles after the strobe, sampled on the strobe |
| sdata_i | input | 32 | Serial data, one line per converter lane |
| rd_win_o | output | 1 | Read window; high during capture cycles |
| sclk_o | output | 1 | Serial read clock; a rising edge requests the next bit |
| word_o | output | 576 | Packed samples, lane n at [18n+17:18n] |
| valid_o | output | 1 | One-cycle pulse marking a new word_o |

## Verification
Two events can fall on the same clock edge. One is the last capture of a window placed at the latest legal start. The other is the strobe that opens the next period. The bench provokes this every few periods by setting the window start to its maximum with a strobe spacing of 50 cycles. It then checks that the finished word still appears with its pulse, and that the new window follows the start value sampled on that same edge. Random window starts, changes of the start value in mid-period, an over-long period and patterned lane data surround these collisions.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;
  localparam int unsigned LANES_DEF    = 32;
  localparam int unsigned SAMPLE_W_DEF = 18;
  localparam int unsigned PERIOD_DEF   = 50;

  typedef struct packed {
    logic shift;  // capture one bit on every lane
    logic last;   // final bit of the window
    logic arm;    // an earlier conversion exists
  } cap_ctl_t;
endpackage

// File: rtl/adc_deser_timing.sv
module adc_deser_timing
  import adc_deser_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = PERIOD_DEF,
  parameter int unsigned SAMPLE_W   = SAMPLE_W_DEF,
  parameter int unsigned CNT_W      = $clog2(PERIOD_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] win_start_i,
  output cap_ctl_t         ctl_o,
  output logic             sclk_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, ws_q;
  logic             active_q, seen_q, arm_q, sclk_q;
  logic [EXT_W-1:0] rel;
  logic             in_win;

  assign rel    = {1'b0, cnt_q} - {1'b0, ws_q};
  assign in_win = active_q && (cnt_q >= ws_q) && (rel < EXT_W'(SAMPLE_W));

  assign ctl_o.shift = in_win;
  assign ctl_o.last  = in_win && (rel == EXT_W'(SAMPLE_W - 1));
  assign ctl_o.arm   = arm_q;
  assign sclk_o      = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ws_q     <= '0;
      active_q <= 1'b0;
      seen_q   <= 1'b0;
      arm_q    <= 1'b0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= in_win;
      if (strobe_i) begin
        cnt_q    <= '0;
        ws_q     <= win_start_i;
        active_q <= 1'b1;
        seen_q   <= 1'b1;
        arm_q    <= seen_q;  // data read in this period is valid only after a prior strobe
      end else if (active_q) begin
        if (cnt_q == CNT_W'(PERIOD_CYC - 1)) active_q <= 1'b0;
        else                                 cnt_q    <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_deser_lane.sv
module adc_deser_lane #(
  parameter int unsigned SAMPLE_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  logic [SAMPLE_W-1:0] sh_q;

  // completed sample including the bit present this cycle
  assign sample_o = {sh_q[SAMPLE_W-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= sample_o;
  end
endmodule

// File: rtl/adc_lane_deser.sv
module adc_lane_deser
  import adc_deser_pkg::*;
#(
  parameter int unsigned LANES      = LANES_DEF,
  parameter int unsigned SAMPLE_W   = SAMPLE_W_DEF,
  parameter int unsigned PERIOD_CYC = PERIOD_DEF,
  localparam int unsigned CNT_W     = $clog2(PERIOD_CYC),
  localparam int unsigned WORD_W    = LANES * SAMPLE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CNT_W-1:0]  win_start_i,
  input  logic [LANES-1:0]  sdata_i,
  output logic              rd_win_o,
  output logic              sclk_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  cap_ctl_t          ctl;
  logic [WORD_W-1:0] packed_next;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  adc_deser_timing #(
    .PERIOD_CYC(PERIOD_CYC),
    .SAMPLE_W  (SAMPLE_W),
    .CNT_W     (CNT_W)
  ) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe_i),
    .win_start_i(win_start_i),
    .ctl_o      (ctl),
    .sclk_o     (sclk_o)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    adc_deser_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (ctl.shift),
      .sdata_i (sdata_i[n]),
      .sample_o(packed_next[n*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ctl.last && ctl.arm;
      if (ctl.last && ctl.arm) word_q <= packed_next;
    end
  end

  assign rd_win_o = ctl.shift;
  assign word_o   = word_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/adc_deser_chk.sv
module adc_deser_chk #(
  parameter int unsigned LANES      = 32,
  parameter int unsigned SAMPLE_W   = 18,
  parameter int unsigned PERIOD_CYC = 50,
  localparam int unsigned CNT_W     = $clog2(PERIOD_CYC),
  localparam int unsigned WORD_W    = LANES * SAMPLE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic [CNT_W-1:0]  win_start_i,
  input logic              rd_win_o,
  input logic              sclk_o,
  input logic [WORD_W-1:0] word_o,
  input logic              valid_o
);
  logic [CNT_W-1:0] run_len;
  logic [1:0]       strobe_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len    <= '0;
      strobe_cnt <= '0;
    end else begin
      run_len <= (rd_win_o && !strobe_i) ? run_len + 1'b1 : '0;
      if (strobe_i && strobe_cnt != 2'd2) strobe_cnt <= strobe_cnt + 1'b1;
    end
  end

  a_r2_ws_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> ({1'b0, win_start_i} <= (CNT_W+1)'(PERIOD_CYC - SAMPLE_W)));

  a_r2_win_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_win_o |-> (run_len < CNT_W'(SAMPLE_W)));

  a_r4_sclk_trails_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_win_o |=> sclk_o);

  a_r7_valid_after_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rd_win_o));

  a_r7_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r8_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  a_r9_needs_prior_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (strobe_cnt == 2'd2));
endmodule

bind adc_lane_deser adc_deser_chk #(
  .LANES     (LANES),
  .SAMPLE_W  (SAMPLE_W),
  .PERIOD_CYC(PERIOD_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strobe_i   (strobe_i),
  .win_start_i(win_start_i),
  .rd_win_o   (rd_win_o),
  .sclk_o     (sclk_o),
  .word_o     (word_o),
  .valid_o    (valid_o)
);

// File: tb/adc_lane_deser_bench.sv
`timescale 1ns/1ps
module adc_lane_deser_bench;
  localparam int LANES = 32, SW = 18, PER = 50, WS_MAX = PER - SW;
  localparam int WORD_W = LANES * SW;
  localparam int N_PER = 320;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              strobe_i = 1'b0;
  logic [5:0]        win_start_i = '0;
  logic [LANES-1:0]  sdata_i = '0;
  logic              rd_win_o, sclk_o, valid_o;
  logic [WORD_W-1:0] word_o;

  always #2.5 clk = ~clk;

  adc_lane_deser u_adc_lane_deser (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe_i), .win_start_i(win_start_i),
    .sdata_i(sdata_i), .rd_win_o(rd_win_o), .sclk_o(sclk_o), .word_o(word_o), .valid_o(valid_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [SW-1:0] prev_d [LANES];
  logic [SW-1:0] cur_d  [LANES];

  function automatic logic [WORD_W-1:0] pack_prev();
    logic [WORD_W-1:0] w;
    for (int l = 0; l < LANES; l++) w[l*SW +: SW] = prev_d[l];
    return w;
  endfunction

  function automatic logic [SW-1:0] gen_sample(int p, int l);
    case (p % 6)
      0: return '1;
      1: return '0;
      2: return (l % 2) ? 18'h2AAAA : 18'h15555;
      3: return SW'(l * 4099 + 1);  // lane-distinct pattern for R6
      default: return SW'($urandom);
    endcase
  endfunction

  task automatic chk_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_word(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c = 0, ws_cur = 0, k = 0, gap = 0, per_len = 20, p = 0;
    bit started = 0, armed = 0, first_seen = 0, coll = 0;
    logic exp_win = 0, exp_sclk = 0, exp_vld = 0;
    logic [WORD_W-1:0] exp_word = '0;
    string tag;

    void'($urandom(32'h5EED1234));
    for (int l = 0; l < LANES; l++) begin prev_d[l] = '0; cur_d[l] = gen_sample(5, l); end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk_bit("R1 valid", valid_o, 1'b0);
    chk_bit("R1 rd_win", rd_win_o, 1'b0);
    chk_bit("R1 sclk", sclk_o, 1'b0);
    chk_word("R1 word", word_o, '0);
    rst_ni = 1'b1;

    while (p < N_PER) begin
      @(negedge clk);
      // checks of the current cycle
      chk_bit(started ? "R2 R3" : "R1", rd_win_o, exp_win);
      chk_bit("R4", sclk_o, exp_sclk);
      chk_bit(exp_vld ? "R7" : "R7 R9", valid_o, exp_vld);
      tag = !exp_vld ? "R8" : (coll ? "R10" : "R5 R6");
      chk_word(tag, word_o, exp_word);

      // drive serial data for this cycle
      exp_sclk = exp_win;
      exp_vld  = 1'b0;
      coll     = 1'b0;
      if (exp_win) begin
        for (int l = 0; l < LANES; l++) sdata_i[l] = prev_d[l][SW-1-k];
        k++;
        if (k == SW && armed) begin
          exp_vld  = 1'b1;
          exp_word = pack_prev();
        end
      end else begin
        sdata_i = LANES'($urandom);  // junk outside the window
      end

      // strobe decision
      if (gap == per_len - 1) begin
        int ws;
        coll = exp_vld && (gap == per_len - 1) && exp_win;
        case (p % 5)
          0: ws = 0;
          1, 2: ws = WS_MAX;  // last capture collides with next strobe (R10)
          default: ws = $urandom_range(WS_MAX, 0);
        endcase
        strobe_i    = 1'b1;
        win_start_i = 6'(ws);
        ws_cur      = ws;
        c = 0; k = 0; gap = 0; started = 1;
        armed = first_seen; first_seen = 1;
        for (int l = 0; l < LANES; l++) begin
          prev_d[l] = cur_d[l];
          cur_d[l]  = gen_sample(p, l);
        end
        p++;
        per_len = (p % 37 == 20) ? 80 : PER;
      end else begin
        strobe_i = 1'b0;
        c++; gap++;
        if (c == 5) win_start_i = 6'($urandom_range(WS_MAX, 0));  // R3: no effect
      end
      exp_win = started && (c >= ws_cur) && (c <= ws_cur + SW - 1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule